// File: doc/BRIEF.md
# Multi-Projection Hit Compressor

This block turns a square binary hit frame of N by N pixels into four one-dimensional projections, so a frame costs 4N bits instead of N squared. Each projection bit is the OR of every hit pixel on one line. The lines are columns, rows, and two wrapped diagonal families that run in opposite directions. The diagonals cut down the ghost combinations left by row and column data alone.

The frame arrives as N row words on a streaming input, with row 0 flagged as the start of the frame. The block does not store the pixels. Column, row and diagonal accumulators take in each row as it arrives. The diagonal accumulators rotate by one position per row, so no variable-width shifter is needed. After the last row, the four vectors are loaded into output registers and a valid strobe is raised for one cycle.

A small controller with two states sequences the frame. `ST_IDLE` waits for a start row and goes to `ST_ACCUM` when one is accepted. `ST_ACCUM` counts rows. A row that is neither the first nor the last keeps the block in `ST_ACCUM`. A new start row in `ST_ACCUM` restarts the frame and stays in `ST_ACCUM`. Row N-1 returns the block to `ST_IDLE`.

Top module: `multi_proj_compressor`

## Requirements
- R1: For a completed frame, `proj_x[c]` is 1 exactly when at least one pixel in column c (bit c of any row word) is hit.
- R2: For a completed frame, `proj_y[r]` is 1 exactly when row word r (the r-th accepted row, counting the start row as 0) has at least one bit set.
- R3: For a completed frame, `proj_u[k]` is 1 exactly when some hit pixel at row r and column c satisfies (r + c) mod N = k.
- R4: For a completed frame, `proj_v[k]` is 1 exactly when some hit pixel at row r and column c satisfies (r - c) mod N = k.
- R5: `proj_valid` is high for exactly one cycle, the cycle after the N-th row of a frame is accepted. At all other times the four projection outputs hold their last values.
- R6: An accepted row with `row_sof` high starts a new frame and discards everything gathered so far. This applies even in the middle of a frame, and the discarded frame produces no `proj_valid`.
- R7: A cycle with `row_valid` low is a gap: it is not counted and adds nothing to the projections. A row with `row_sof` low that arrives while no frame is open is ignored.
- R8: While reset is asserted and after it is released, `proj_valid` is 0 and all four projection vectors are 0.
- R9: The start row of the next frame can be accepted in the cycle right after the last row of a frame. The result of the finished frame is not disturbed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_valid | input | 1 | Row word present this cycle |
| row_sof | input | 1 | Present row is row 0 of a new frame |
| row_bits | input | N | Hit bits of the row; bit c is column c |
| proj_valid | output | 1 | One-cycle strobe: projections of a completed frame are new |
| proj_x | output | N | Column projection |
| proj_y | output | N | Row projection |
| proj_u | output | N | Sum-diagonal projection, index (r + c) mod N |
| proj_v | output | N | Difference-diagonal projection, index (r - c) mod N |

## Verification
Two events can fall in the same cycle: the output load of a finished frame, and the acceptance of the next frame's start row, which clears the accumulators. The bench provokes this by sending two frames back to back with no idle cycle between them. It checks that the output vectors show the first frame in the strobe cycle and the second frame one frame later. A second overlap is a start row that arrives inside an open frame. The bench judges this by feeding a partial all-ones frame and then a full frame, and expecting only the second frame's projections.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } mpc_state_e;

endpackage

// File: rtl/mpc_frame_ctrl.sv
module mpc_frame_ctrl
    import mpc_pkg::*;
#(
    parameter int N = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_valid,
    input  logic row_sof,
    output logic acc_start,
    output logic acc_step,
    output logic acc_last
);

    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_ROW = CW'(N - 1);

    mpc_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register and row counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and strobes
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        acc_start = 1'b0;
        acc_step  = 1'b0;
        acc_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (row_valid && row_sof) begin
                    acc_start = 1'b1;
                    state_d   = ST_ACCUM;
                    cnt_d     = CW'(1);
                end
            end
            ST_ACCUM: begin
                if (row_valid && row_sof) begin
                    acc_start = 1'b1;
                    cnt_d     = CW'(1);
                end else if (row_valid) begin
                    acc_step = 1'b1;
                    if (cnt_q == LAST_ROW) begin
                        acc_last = 1'b1;
                        state_d  = ST_IDLE;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
        endcase
    end

    // R7: the row count never passes the last row index
    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_ROW);

    // R6: an idle controller holds no partial count
    assert_idle_cnt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0));

    // R5: after a last row the next row cannot continue the same frame
    assert_last_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_last |=> !acc_step);

endmodule

// File: rtl/mpc_ortho_acc.sv
module mpc_ortho_acc #(
    parameter int N = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic [N-1:0] row,
    output logic [N-1:0] x_nx,
    output logic [N-1:0] y_nx
);

    logic [N-1:0] x_q;
    logic [N-1:0] y_q;
    logic         row_any;

    assign row_any = |row;

    // Column OR and row shift register (row 0 ends at bit 0)
    always_comb begin
        x_nx = x_q;
        y_nx = y_q;
        if (start) begin
            x_nx = row;
            y_nx = {row_any, {(N-1){1'b0}}};
        end else if (step) begin
            x_nx = x_q | row;
            y_nx = {row_any, y_q[N-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            x_q <= x_nx;
            y_q <= y_nx;
        end
    end

    // R1: within a frame the column accumulator only gains bits
    assert_x_monotone_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> ((x_q & $past(x_q)) == $past(x_q)));

endmodule

// File: rtl/mpc_diag_acc.sv
module mpc_diag_acc #(
    parameter int N = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic [N-1:0] row,
    output logic [N-1:0] u_fin,
    output logic [N-1:0] v_fin
);

    // s_q[c] tracks U[(c + r) mod N]; d_q[c] tracks V[(r - c) mod N]
    logic [N-1:0] s_q, s_nx;
    logic [N-1:0] d_q, d_nx;
    logic [N-1:0] d_al;

    always_comb begin
        s_nx = s_q;
        d_nx = d_q;
        if (start) begin
            s_nx = row;
            d_nx = row;
        end else if (step) begin
            s_nx = {s_q[0], s_q[N-1:1]} | row;
            d_nx = {d_q[N-2:0], d_q[N-1]} | row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            d_q <= '0;
        end else begin
            s_q <= s_nx;
            d_q <= d_nx;
        end
    end

    // Final alignment after row N-1: one more rotation, then index mapping
    assign u_fin = {s_nx[0], s_nx[N-1:1]};
    assign d_al  = {d_nx[N-2:0], d_nx[N-1]};

    for (genvar k = 0; k < N; k++) begin : g_vmap
        assign v_fin[k] = d_al[(N - k) % N];
    end

    // R3/R4: rotation keeps the hit count of the diagonal state when the row is empty
    assert_rot_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && (row == '0)) |=> ($countones(s_q) == $countones($past(s_q))));
    assert_rot_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && (row == '0)) |=> ($countones(d_q) == $countones($past(d_q))));

endmodule

// File: rtl/multi_proj_compressor.sv
module multi_proj_compressor
    import mpc_pkg::*;
#(
    parameter int N = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         row_valid,
    input  logic         row_sof,
    input  logic [N-1:0] row_bits,
    output logic         proj_valid,
    output logic [N-1:0] proj_x,
    output logic [N-1:0] proj_y,
    output logic [N-1:0] proj_u,
    output logic [N-1:0] proj_v
);

    logic         acc_start, acc_step, acc_last;
    logic [N-1:0] x_nx, y_nx, u_fin, v_fin;

    mpc_frame_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .row_sof   (row_sof),
        .acc_start (acc_start),
        .acc_step  (acc_step),
        .acc_last  (acc_last)
    );

    mpc_ortho_acc #(.N(N)) u_ortho (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc_start),
        .step  (acc_step),
        .row   (row_bits),
        .x_nx  (x_nx),
        .y_nx  (y_nx)
    );

    mpc_diag_acc #(.N(N)) u_diag (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acc_start),
        .step  (acc_step),
        .row   (row_bits),
        .u_fin (u_fin),
        .v_fin (v_fin)
    );

    // Output latch on the last row of a frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proj_valid <= 1'b0;
            proj_x     <= '0;
            proj_y     <= '0;
            proj_u     <= '0;
            proj_v     <= '0;
        end else begin
            proj_valid <= acc_last;
            if (acc_last) begin
                proj_x <= x_nx;
                proj_y <= y_nx;
                proj_u <= u_fin;
                proj_v <= v_fin;
            end
        end
    end

    // R5: the strobe lasts one cycle
    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        proj_valid |=> !proj_valid);

    // R5: the strobe follows an accepted non-start row
    assert_valid_after_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        proj_valid |-> $past(row_valid && !row_sof));

    // R5: outputs hold while no strobe
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !proj_valid |-> ($stable(proj_x) && $stable(proj_y) && $stable(proj_u) && $stable(proj_v)));

    // R1/R2/R3/R4: a frame with any hit sets every projection, an empty one none
    assert_nonempty_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
        proj_valid |-> (((|proj_x) == (|proj_y)) && ((|proj_x) == (|proj_u)) && ((|proj_x) == (|proj_v))));

endmodule

// File: tb/sim_multi_proj_compressor.sv
`timescale 1ns/1ps
module sim_multi_proj_compressor;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         row_valid = 1'b0;
    logic         row_sof = 1'b0;
    logic [N-1:0] row_bits = '0;
    logic         proj_valid;
    logic [N-1:0] proj_x, proj_y, proj_u, proj_v;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] frm [N];
    logic [N-1:0] ex, ey, eu, ev;

    always #4 clk = ~clk;

    multi_proj_compressor #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_sof(row_sof),
        .row_bits(row_bits), .proj_valid(proj_valid), .proj_x(proj_x),
        .proj_y(proj_y), .proj_u(proj_u), .proj_v(proj_v)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic compute();
        ex = '0; ey = '0; eu = '0; ev = '0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                if (frm[r][c]) begin
                    ex[c] = 1'b1;
                    ey[r] = 1'b1;
                    eu[(r + c) % N] = 1'b1;
                    ev[(r - c + N) % N] = 1'b1;
                end
    endtask

    task automatic drive_row(input logic [N-1:0] bits, input logic sof);
        @(negedge clk);
        row_valid = 1'b1; row_sof = sof; row_bits = bits;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        row_valid = 1'b0; row_sof = 1'b0; row_bits = '0;
    endtask

    task automatic check_all(input string tag);
        chk({"R5 valid ", tag}, {{(N-1){1'b0}}, proj_valid}, {{(N-1){1'b0}}, 1'b1});
        chk({"R1 ", tag}, proj_x, ex);
        chk({"R2 ", tag}, proj_y, ey);
        chk({"R3 ", tag}, proj_u, eu);
        chk({"R4 ", tag}, proj_v, ev);
    endtask

    task automatic check_hold(input string tag);
        chk({"R5 pulse ", tag}, {{(N-1){1'b0}}, proj_valid}, '0);
        chk({"R5 hold ", tag}, proj_u ^ proj_v ^ proj_x ^ proj_y, eu ^ ev ^ ex ^ ey);
    endtask

    // Sends frm; gap inserts an idle cycle between rows (R7)
    task automatic send_frame(input bit gap, input string tag);
        compute();
        for (int r = 0; r < N; r++) begin
            drive_row(frm[r], r == 0);
            if (gap && r < N - 1) idle_cycle();
        end
        idle_cycle();
        check_all(tag);
        idle_cycle();
        check_hold(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {{(N-1){1'b0}}, proj_valid}, '0);
        chk("R8 reset x", proj_x, '0);
        chk("R8 reset uv", proj_u | proj_v | proj_y, '0);
        rst_n = 1'b1;
        idle_cycle();
        chk("R8 after release", {{(N-1){1'b0}}, proj_valid}, '0);

        // Empty frame
        for (int r = 0; r < N; r++) frm[r] = '0;
        send_frame(1'b0, "empty");

        // Every single-hit position, corners included
        for (int rr = 0; rr < N; rr++)
            for (int cc = 0; cc < N; cc++) begin
                for (int r = 0; r < N; r++) frm[r] = '0;
                frm[rr][cc] = 1'b1;
                send_frame(1'b0, "single");
            end

        // Random frames, with and without gaps (R7)
        for (int i = 0; i < 40; i++) begin
            for (int r = 0; r < N; r++) frm[r] = N'($urandom);
            send_frame(i[0], i[0] ? "R7 gaps" : "random");
        end

        // Back-to-back frames (R9)
        begin
            logic [N-1:0] fb [N];
            logic [N-1:0] ax, ay, au, av;
            for (int r = 0; r < N; r++) begin
                frm[r] = N'($urandom);
                fb[r]  = N'($urandom);
            end
            compute();
            ax = ex; ay = ey; au = eu; av = ev;
            for (int r = 0; r < N; r++) drive_row(frm[r], r == 0);
            drive_row(fb[0], 1'b1);
            chk("R9 strobe with next sof", {{(N-1){1'b0}}, proj_valid}, {{(N-1){1'b0}}, 1'b1});
            chk("R9 first x", proj_x, ax);
            chk("R9 first y", proj_y, ay);
            chk("R9 first u", proj_u, au);
            chk("R9 first v", proj_v, av);
            for (int r = 1; r < N; r++) drive_row(fb[r], 1'b0);
            for (int r = 0; r < N; r++) frm[r] = fb[r];
            compute();
            idle_cycle();
            check_all("R9 second");
            idle_cycle();
            check_hold("R9 second");
        end

        // Restart mid-frame (R6)
        for (int r = 0; r < 3; r++) drive_row('1, r == 0);
        for (int r = 0; r < N; r++) frm[r] = '0;
        frm[N-1][0] = 1'b1;
        compute();
        drive_row(frm[0], 1'b1);
        chk("R6 no strobe for abandoned frame", {{(N-1){1'b0}}, proj_valid}, '0);
        for (int r = 1; r < N; r++) drive_row(frm[r], 1'b0);
        idle_cycle();
        check_all("R6 restart");
        idle_cycle();

        // Stray rows while idle (R7)
        for (int i = 0; i < 3; i++) begin
            drive_row('1, 1'b0);
            chk("R7 stray no strobe", {{(N-1){1'b0}}, proj_valid}, '0);
            chk("R7 stray hold", proj_x, ex);
        end
        idle_cycle();
        for (int r = 0; r < N; r++) frm[r] = N'(r + 1);
        send_frame(1'b0, "R7 after stray");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule